// File: doc/BRIEF.md
# Memory Controller Interrupt Register Block

This block is the software-visible control face of an on-chip RAM controller. It gathers up to eleven hardware error or event sources into a status register and combines that register with a mask to drive a single level-sensitive interrupt line. Software clears status bits by writing ones to them. The mask cannot be written directly. Software unmasks sources by writing ones to an unmask command word and masks them by writing ones to a mask command word. Both command words always read back as zero.

Two more registers sit beside the interrupt logic. A four-bit error-configuration register resets to all ones and is driven out to the controller datapath. A read-only information register reports the RAM capacity as a small code. That code is taken from a size parameter, and any size outside the supported set stops elaboration with an error.

The bus is a simple word-addressed port that carries only full 32-bit words. Read data is combinational from the address. A write takes effect at the clock edge where the write strobe is high.

Top module: `memc_irq_regs`

## Requirements
- R1: After reset, status reads 0x000, mask reads 0x7FF, error configuration reads 0xF, `irq_o` is low and `err_cfg_o` is 0xF.
- R2: A high bit on `evt_i` at a clock edge sets the matching status bit. The bit reads back as 1 from word address 0x0 after that edge.
- R3: A write to word address 0x0 clears each status bit whose write-data bit is 1 and leaves the others unchanged. Status bits [31:11] read as zero.
- R4: If an event and a clearing write hit the same status bit at the same edge, the bit ends up set.
- R5: The mask, read at word address 0x1, ignores bus writes to that address.
- R6: A write to word address 0x2 clears each mask bit whose write-data bit is 1. Zero bits leave the mask unchanged. Address 0x2 reads as zero.
- R7: A write to word address 0x3 sets each mask bit whose write-data bit is 1. Address 0x3 reads as zero.
- R8: `irq_o` is high exactly when some status bit is set and its mask bit is clear. It follows every change of status or mask from the next edge on.
- R9: Word address 0x4 is a 4-bit read/write error configuration in bits [3:0]. It is driven on `err_cfg_o`, and bits [31:4] read as zero.
- R10: Word address 0x5 reads the size code in bits [3:0]: 64 KiB gives 0, 128 KiB gives 1, 256 KiB gives 2, 512 KiB gives 3 and 1024 KiB gives 4 (the default). Writes to this address are ignored.
- R11: Word addresses 0x6 to 0xF read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Word address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| evt_i | input | NUM_SRC | Event inputs that set status bits |
| irq_o | output | 1 | Level interrupt |
| err_cfg_o | output | 4 | Error configuration bits |

## Verification
The checker looks at every cycle. It confirms that an event always leaves its status bit set, that the unmask and mask commands leave exactly the addressed mask bits cleared or set, and that a write to the mask address never moves the mask. It also confirms that a full clear with no events drops the interrupt, and that unmapped and information reads carry no stray bits. The directed scenarios cover what needs a chosen history: the reset values, the exact read-back values, the set-over-clear race, the error-configuration output, and the size code of two differently sized instances.

// File: rtl/memc_irq_regs.sv
module memc_irq_regs #(
  parameter int NUM_SRC = 11,
  parameter int ADDR_W  = 4,
  parameter int RAM_KIB = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NUM_SRC-1:0] evt_i,
  output logic              irq_o,
  output logic [3:0]        err_cfg_o
);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_UNMSK = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_MSK   = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_ECFG  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_INFO  = ADDR_W'(5);

  function automatic logic [3:0] size_code(int kib);
    case (kib)
      64:      return 4'd0;
      128:     return 4'd1;
      256:     return 4'd2;
      512:     return 4'd3;
      1024:    return 4'd4;
      default: return 4'hF;
    endcase
  endfunction

  localparam logic [3:0] SIZE_CODE = size_code(RAM_KIB);

  if (SIZE_CODE == 4'hF) begin : g_bad_size
    $error("memc_irq_regs: unsupported RAM_KIB value");
  end

  logic [NUM_SRC-1:0] stat_q, mask_q;
  logic [3:0]         ecfg_q;
  logic [NUM_SRC-1:0] wbits;

  assign wbits = reg_wdata[NUM_SRC-1:0];

  wire wr_stat  = reg_wr && reg_addr == A_STAT;
  wire wr_unmsk = reg_wr && reg_addr == A_UNMSK;
  wire wr_msk   = reg_wr && reg_addr == A_MSK;
  wire wr_ecfg  = reg_wr && reg_addr == A_ECFG;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '1;
      ecfg_q <= 4'hF;
    end else begin
      stat_q <= (stat_q & ~(wr_stat ? wbits : '0)) | evt_i;
      mask_q <= (mask_q & ~(wr_unmsk ? wbits : '0)) | (wr_msk ? wbits : '0);
      if (wr_ecfg) ecfg_q <= reg_wdata[3:0];
    end
  end

  assign irq_o     = |(stat_q & ~mask_q);
  assign err_cfg_o = ecfg_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_STAT:  reg_rdata[NUM_SRC-1:0] = stat_q;
      A_MASK:  reg_rdata[NUM_SRC-1:0] = mask_q;
      A_ECFG:  reg_rdata[3:0] = ecfg_q;
      A_INFO:  reg_rdata[3:0] = SIZE_CODE;
      default: reg_rdata = '0;
    endcase
  end

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata[31:NUM_SRC];
endmodule

// File: rtl/memc_irq_regs_chk.sv
module memc_irq_regs_chk #(
  parameter int NUM_SRC = 11,
  parameter int ADDR_W  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic               reg_wr,
  input logic [31:0]        reg_wdata,
  input logic [31:0]        reg_rdata,
  input logic [NUM_SRC-1:0] evt_i,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] stat_q,
  input logic [NUM_SRC-1:0] mask_q
);
  a_r2_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((stat_q & $past(evt_i)) == $past(evt_i)));

  a_r5_mask_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(1)) |=> $stable(mask_q));

  a_r6_unmask: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(2)) |=> ((mask_q & $past(reg_wdata[NUM_SRC-1:0])) == '0));

  a_r7_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(3)) |=>
      ((mask_q & $past(reg_wdata[NUM_SRC-1:0])) == $past(reg_wdata[NUM_SRC-1:0])));

  a_r8_clear_all_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(0) && reg_wdata[NUM_SRC-1:0] == '1 && evt_i == '0) |=> !irq_o);

  a_r10_info_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(5)) |-> (reg_rdata[31:4] == '0));

  a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr > ADDR_W'(5)) |-> (reg_rdata == '0));
endmodule

bind memc_irq_regs memc_irq_regs_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_i(evt_i),
  .irq_o(irq_o), .stat_q(stat_q), .mask_q(mask_q)
);

// File: tb/memc_irq_regs_tb.sv
`timescale 1ns/1ps
module memc_irq_regs_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 0;
  logic [31:0] reg_wdata = '0;
  logic [10:0] evt_i = '0;
  logic [31:0] reg_rdata, rdata64;
  logic        irq_o, irq64;
  logic [3:0]  err_cfg_o, ecfg64;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  memc_irq_regs u_dut (.clk, .rst_n, .reg_addr, .reg_wr, .reg_wdata,
    .reg_rdata, .evt_i, .irq_o, .err_cfg_o);

  memc_irq_regs #(.RAM_KIB(64)) u_dut64 (.clk, .rst_n, .reg_addr, .reg_wr,
    .reg_wdata, .reg_rdata(rdata64), .evt_i, .irq_o(irq64), .err_cfg_o(ecfg64));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic rd_chk(string req, logic [3:0] a, logic [31:0] exp);
    reg_addr = a; #0.5;
    check(req, reg_rdata, exp);
  endtask

  task automatic pulse(logic [10:0] e);
    @(negedge clk); evt_i = e;
    @(negedge clk); evt_i = '0;
  endtask

  task automatic t_reset;
    rd_chk("R1 status", 4'h0, 32'h0);
    rd_chk("R1 mask", 4'h1, 32'h7FF);
    rd_chk("R1 ecfg", 4'h4, 32'hF);
    check("R1 irq", 32'(irq_o), 32'h0);
    check("R1 err_cfg_o", 32'(err_cfg_o), 32'hF);
  endtask

  task automatic t_event_and_irq;
    pulse(11'h001);
    rd_chk("R2 event sets bit0", 4'h0, 32'h1);
    check("R8 masked source keeps irq low", 32'(irq_o), 32'h0);
    wr(4'h2, 32'h0000_0001);
    rd_chk("R6 unmask clears bit0", 4'h1, 32'h7FE);
    rd_chk("R6 unmask reads zero", 4'h2, 32'h0);
    check("R8 unmasked pending raises irq", 32'(irq_o), 32'h1);
    wr(4'h3, 32'h0000_0001);
    rd_chk("R7 mask sets bit0", 4'h1, 32'h7FF);
    rd_chk("R7 mask cmd reads zero", 4'h3, 32'h0);
    check("R8 remasked drops irq", 32'(irq_o), 32'h0);
    wr(4'h2, 32'h0000_0001);
    check("R8 irq back", 32'(irq_o), 32'h1);
  endtask

  task automatic t_clear;
    pulse(11'h7FF);
    rd_chk("R3 all bits set, upper zero", 4'h0, 32'h7FF);
    wr(4'h0, 32'h0);
    rd_chk("R3 zero write keeps status", 4'h0, 32'h7FF);
    wr(4'h0, 32'hFFFF_F800 | 32'h0F0);
    rd_chk("R3 partial clear", 4'h0, 32'h70F);
    wr(4'h0, 32'h1);
    rd_chk("R3 clear bit0", 4'h0, 32'h70E);
    check("R8 bit0 clear, masked rest keep irq low", 32'(irq_o), 32'h0);
    wr(4'h0, 32'hFFFF_FFFF);
    rd_chk("R3 clear all", 4'h0, 32'h0);
  endtask

  task automatic t_race;
    @(negedge clk); reg_addr = 4'h0; reg_wdata = 32'h8; reg_wr = 1; evt_i = 11'h008;
    @(negedge clk); reg_wr = 0; reg_wdata = '0; evt_i = '0;
    rd_chk("R4 set wins over clear", 4'h0, 32'h8);
    wr(4'h0, 32'h8);
    rd_chk("R4 later clear works", 4'h0, 32'h0);
  endtask

  task automatic t_mask_ro;
    wr(4'h1, 32'h0);
    rd_chk("R5 mask ignores write", 4'h1, 32'h7FE);
    wr(4'h3, 32'h0000_0600);
    rd_chk("R7 mask sets bits 10,9", 4'h1, 32'h7FE);
    wr(4'h2, 32'h0000_0606);
    rd_chk("R6 unmask bits 1,2,9,10", 4'h1, 32'h1F8);
  endtask

  task automatic t_ecfg_info;
    wr(4'h4, 32'hFFFF_FFA5);
    rd_chk("R9 ecfg low 4 bits", 4'h4, 32'h5);
    check("R9 err_cfg_o", 32'(err_cfg_o), 32'h5);
    rd_chk("R10 size code 1024 KiB", 4'h5, 32'h4);
    check("R10 size code 64 KiB", rdata64, 32'h0);
    wr(4'h5, 32'hFFFF_FFFF);
    rd_chk("R10 info ignores write", 4'h5, 32'h4);
  endtask

  task automatic t_unmapped;
    for (int a = 6; a < 16; a++) begin
      wr(4'(a), 32'hFFFF_FFFF);
      rd_chk("R11 unmapped reads zero", 4'(a), 32'h0);
    end
    rd_chk("R11 status untouched", 4'h0, 32'h0);
    rd_chk("R11 mask untouched", 4'h1, 32'h1F8);
    rd_chk("R11 ecfg untouched", 4'h4, 32'h5);
  endtask

  initial begin
    #10 @(negedge clk); rst_n = 1;
    t_reset();
    t_event_and_irq();
    t_clear();
    t_race();
    t_mask_ro();
    t_ecfg_info();
    t_unmapped();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule